// File: doc/BRIEF.md
# Synchronous SCSI Data-Out Sender

This block moves a block of bytes from a target onto the SCSI data lines in synchronous mode. Bytes are not handshaken one at a time. The sender takes bytes from a valid/ready stream. It places each byte, inverted for the active-low bus, on the data lines and asserts REQ (also active low) on the same clock edge. It holds REQ for half a programmed period and then releases it for the other half. The initiator answers each REQ with an ACK pulse, and those pulses may lag behind. A down-counter loaded with the transfer length at start tracks the ACKs still owed. Before each new byte the sender checks that counter, so that no more than the negotiated offset of REQs is ever outstanding.

After the last byte the data lines are held for one extra half period and then released. The sender then waits until every ACK has arrived before it pulses done. A bus reset ends the transfer at once from any busy state. The remaining ACK count stays visible on `acks_left`. An offset of zero is not legal for synchronous transfers, so a start with that offset is refused and flagged.

The controller is a state machine with seven states:
- `S_IDLE`: waits for a start.
- `S_FETCH`: waits for a byte and for room under the offset.
- `S_REQ`: REQ is asserted.
- `S_GAP`: REQ is released.
- `S_TAIL`: the extra half period after the last byte.
- `S_DRAIN`: waits for the remaining ACKs.
- `S_DONE`: a single-cycle completion state.

Its transitions are:
- IDLE→FETCH on a legal start with a non-zero length.
- IDLE→DRAIN on a legal start with zero length.
- FETCH→REQ on a byte handshake.
- REQ→GAP at the end of the half period.
- GAP→REQ when the next byte is ready and room exists at the end of the gap.
- GAP→FETCH otherwise, while bytes remain.
- GAP→TAIL after the last byte.
- TAIL→DRAIN at the end of the half period.
- DRAIN→DONE when the count is zero.
- DONE→IDLE.
- Any busy state→IDLE on bus reset.

Top module: `sds_sender`

## Requirements
- R1: After reset and whenever the block is idle: `req_n`=1, `data_n`=all ones, `parity_n`=1 (lines released), `busy`=0, `done`=0, `in_ready`=0.
- R2: A start while idle with `cfg_offset`=0 leaves the block idle and sets `cfg_err`=1. A start with a non-zero offset clears `cfg_err`, sets `busy` and loads `acks_left` with `xfer_len` on that same edge.
- R3: For each accepted byte B, `data_n`=~B and `parity_n`=^B (the true parity bit makes the count of ones in byte plus parity odd, and it is driven inverted). The data and the falling edge of `req_n` appear on the same clock edge, and the data stay stable while `req_n` is low.
- R4: With a half period of H = max(1, ceil(`cfg_period`*2 / CLK_NS)) cycles, where `cfg_period` is in 4 ns units, `req_n` stays low for exactly H cycles. When the next byte is available and allowed, `req_n` stays high for exactly H cycles between pulses.
- R5: A byte is accepted only when `acks_left` + 1 <= (bytes still to send, including this one) + `cfg_offset`. At most `cfg_offset` REQs are therefore ever unacknowledged.
- R6: `acks_left` decreases by one for each falling edge of `ack_n`, seen through a two-stage synchronizer. It never goes below zero and never rises during a transfer.
- R7: After the last REQ rises, the data stay driven for 2H cycles (the gap plus one extra half period) and are then released, with `req_n` staying high.
- R8: `done` is a single-cycle pulse, raised only after the lines are released and `acks_left` is 0. `busy` falls on the next cycle.
- R9: `bus_rst` high in any busy state returns the block to idle on the next edge, with the lines released and no `done`. `acks_left` keeps the count still owed.
- R10: A legal start with `xfer_len`=0 produces `done` without any REQ pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_NS ns |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| xfer_len | input | LEN_W | Number of bytes in the transfer |
| cfg_period | input | PER_W | Byte period in 4 ns units |
| cfg_offset | input | OFS_W | Maximum unacknowledged REQs |
| in_data | input | 8 | Byte stream data |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| ack_n | input | 1 | Active-low ACK from the initiator (asynchronous) |
| bus_rst | input | 1 | Bus reset, aborts the transfer |
| req_n | output | 1 | Active-low REQ |
| data_n | output | 8 | Active-low data lines (all ones when released) |
| parity_n | output | 1 | Active-low odd-parity line (1 when released) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Single-cycle completion pulse |
| cfg_err | output | 1 | Last start was refused because the offset was zero |
| acks_left | output | LEN_W | ACK pulses still owed |

## Verification
The properties assume that `cfg_period`, `cfg_offset` and `xfer_len` are held steady for the whole transfer. They also assume that `ack_n` pulses are at least one cycle low and one cycle high, so that the synchronizer sees every edge, and that the initiator never sends more ACKs during a transfer than REQs it has seen. The bench changes the configuration only while the block is idle. Its ACK model answers only REQs it has observed, one low cycle and one high cycle each, and a budget lets a test withhold ACKs to hold the sender against the offset. Extra ACK pulses are sent only while the block is idle, to check that the counter saturates at zero.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_REQ   = 3'd2,
        S_GAP   = 3'd3,
        S_TAIL  = 3'd4,
        S_DRAIN = 3'd5,
        S_DONE  = 3'd6
    } sds_state_t;

    // Bus-level parity line: active low, odd parity over byte + parity bit.
    function automatic logic bus_parity_n(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/sds_half_timer.sv
// Measures one half period by accumulating elapsed nanoseconds per clock;
// the phase ends in the first cycle whose total reaches period*2 ns, which
// rounds the half period up to whole clock cycles without a divider.
module sds_half_timer #(
    parameter int PER_W  = 8,
    parameter int CLK_NS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             phase_end
);
    localparam int ACC_W = PER_W + 2 + $clog2(CLK_NS + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] target;

    assign target    = ACC_W'({period, 1'b0});
    assign phase_end = (acc_q >= target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart) begin
            acc_q <= ACC_W'(CLK_NS);
        end else if (!phase_end) begin
            acc_q <= acc_q + ACC_W'(CLK_NS);
        end
    end
endmodule

// File: rtl/sds_ack_tally.sv
// Synchronizes the asynchronous ACK line and counts its falling edges
// downward from the loaded transfer length, saturating at zero.
module sds_ack_tally #(
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic [LEN_W-1:0] count
);
    // stages 0..SYNC_STAGES-1 synchronize, the last stage holds the previous value
    logic [SYNC_STAGES:0] pipe_q;
    logic                 ack_fall;
    logic [LEN_W-1:0]     count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q[0] <= ack_n;
            for (int i = 1; i <= SYNC_STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign ack_fall = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (ack_fall && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/sds_sender.sv
module sds_sender
    import sds_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int PER_W       = 8,
    parameter int OFS_W       = 5,
    parameter int CLK_NS      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             ack_n,
    input  logic             bus_rst,
    output logic             req_n,
    output logic [7:0]       data_n,
    output logic             parity_n,
    output logic             busy,
    output logic             done,
    output logic             cfg_err,
    output logic [LEN_W-1:0] acks_left
);
    localparam int CMP_W = LEN_W + 2;

    sds_state_t       state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic [7:0]       byte_q;
    logic             first_q;
    logic             err_q;

    logic             phase_end;
    logic             phase_go;
    logic             accept_start;
    logic             room;
    logic             take_byte;
    logic             lines_on;
    logic [CMP_W-1:0] owed_next;
    logic [CMP_W-1:0] allowance;

    assign accept_start = (state_q == S_IDLE) && start && (cfg_offset != '0);

    sds_half_timer #(
        .PER_W  (PER_W),
        .CLK_NS (CLK_NS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (phase_go),
        .period    (cfg_period),
        .phase_end (phase_end)
    );

    sds_ack_tally #(
        .LEN_W       (LEN_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (ack_n),
        .load     (accept_start),
        .load_val (xfer_len),
        .count    (acks_left)
    );

    // Offset throttle: ACKs still owed after this byte must not exceed
    // the bytes still to send after it plus the offset.
    assign owed_next = CMP_W'(acks_left) + CMP_W'(1);
    assign allowance = CMP_W'(rem_q) + CMP_W'(cfg_offset);
    assign room      = (owed_next <= allowance);

    assign in_ready  = !bus_rst && room && (rem_q != '0) &&
                       ((state_q == S_FETCH) || (state_q == S_GAP && phase_end));
    assign take_byte = in_ready && in_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept_start) begin
                    state_d = (xfer_len == '0) ? S_DRAIN : S_FETCH;
                end
            end
            S_FETCH: begin
                if (bus_rst)        state_d = S_IDLE;
                else if (take_byte) state_d = S_REQ;
            end
            S_REQ: begin
                if (bus_rst)        state_d = S_IDLE;
                else if (phase_end) state_d = S_GAP;
            end
            S_GAP: begin
                if (bus_rst)             state_d = S_IDLE;
                else if (phase_end) begin
                    if (rem_q == '0)     state_d = S_TAIL;
                    else if (take_byte)  state_d = S_REQ;
                    else                 state_d = S_FETCH;
                end
            end
            S_TAIL: begin
                if (bus_rst)        state_d = S_IDLE;
                else if (phase_end) state_d = S_DRAIN;
            end
            S_DRAIN: begin
                if (bus_rst)                state_d = S_IDLE;
                else if (acks_left == '0)   state_d = S_DONE;
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign phase_go = (state_d != state_q) &&
                      ((state_d == S_REQ) || (state_d == S_GAP) || (state_d == S_TAIL));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transfer bookkeeping: remaining bytes, current byte, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            byte_q  <= '0;
            first_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                err_q <= (cfg_offset == '0);
            end
            if (accept_start) begin
                rem_q   <= xfer_len;
                first_q <= 1'b1;
            end else if (take_byte) begin
                rem_q   <= rem_q - 1'b1;
                byte_q  <= in_data;
                first_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        lines_on = (state_q == S_REQ) || (state_q == S_GAP) || (state_q == S_TAIL) ||
                   ((state_q == S_FETCH) && !first_q);
        req_n    = (state_q != S_REQ);
        data_n   = lines_on ? ~byte_q : 8'hFF;
        parity_n = lines_on ? bus_parity_n(byte_q) : 1'b1;
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        cfg_err  = err_q;
    end
endmodule

// File: rtl/sds_sender_chk.sv
module sds_sender_chk #(
    parameter int LEN_W = 16,
    parameter int OFS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OFS_W-1:0] cfg_offset,
    input logic             bus_rst,
    input logic             req_n,
    input logic [7:0]       data_n,
    input logic             parity_n,
    input logic             busy,
    input logic             done,
    input logic             cfg_err,
    input logic [LEN_W-1:0] acks_left
);
    logic released;
    assign released = (data_n == 8'hFF) && parity_n;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (req_n && released));

    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_offset == '0) |=> (!busy && cfg_err));

    p_odd_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !released |-> ((^{~data_n, ~parity_n}) == 1'b1));

    p_req_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> !released);

    p_data_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n)) |-> $stable(data_n));

    p_tally_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (acks_left <= $past(acks_left)));

    p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acks_left == '0 && req_n && released));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && busy) |=> (!busy && !done));
endmodule

bind sds_sender sds_sender_chk #(
    .LEN_W (LEN_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_offset (cfg_offset),
    .bus_rst    (bus_rst),
    .req_n      (req_n),
    .data_n     (data_n),
    .parity_n   (parity_n),
    .busy       (busy),
    .done       (done),
    .cfg_err    (cfg_err),
    .acks_left  (acks_left)
);

// File: tb/sds_sender_tb.sv
module sds_sender_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int PER_W = 8;
    localparam int OFS_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [PER_W-1:0] cfg_period = 8'd5;
    logic [OFS_W-1:0] cfg_offset = 5'd4;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             ack_n = 1'b1;
    logic             bus_rst = 1'b0;
    logic             req_n;
    logic [7:0]       data_n;
    logic             parity_n;
    logic             busy;
    logic             done;
    logic             cfg_err;
    logic [LEN_W-1:0] acks_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    sds_sender #(
        .LEN_W (LEN_W), .PER_W (PER_W), .OFS_W (OFS_W), .CLK_NS (CLK_PERIOD)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .xfer_len (xfer_len),
        .cfg_period (cfg_period), .cfg_offset (cfg_offset),
        .in_data (in_data), .in_valid (in_valid), .in_ready (in_ready),
        .ack_n (ack_n), .bus_rst (bus_rst), .req_n (req_n), .data_n (data_n),
        .parity_n (parity_n), .busy (busy), .done (done), .cfg_err (cfg_err),
        .acks_left (acks_left)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((k * 29 + s * 7 + 3) & 255);
    endfunction

    function automatic int half_cyc(input int per);
        int h;
        h = (per * 2 + CLK_PERIOD - 1) / CLK_PERIOD;
        return (h < 1) ? 1 : h;
    endfunction

    // monitor / ACK model / byte feeder state
    int cyc = 0;
    int seed = 0;
    int req_count = 0;
    int pending = 0;
    int budget = 0;
    int idx = 0;
    int feed_len = 0;
    bit hs_pend = 0;
    int done_cnt = 0;
    int low_len = 0;
    int lmin = 0, lmax = 0, gmin = 0, gmax = 0;
    int last_rise = 0;
    int tail_len = -1;
    bit prev_req = 1;
    bit prev_drv = 0;

    always @(negedge clk) begin
        bit drv;
        cyc++;
        drv = !((data_n == 8'hFF) && parity_n);
        if (rst_n) begin
            if (prev_req && !req_n) begin
                if (req_count > 0) begin
                    int g;
                    g = cyc - last_rise;
                    if (gmin == 0 || g < gmin) gmin = g;
                    if (g > gmax) gmax = g;
                end
                check(~data_n == pat(seed, req_count), "R3", "byte on bus",
                      int'(~data_n), int'(pat(seed, req_count)));
                check((^{~data_n, ~parity_n}) == 1'b1, "R3", "odd parity",
                      int'(parity_n), int'(^(~data_n)));
                req_count++;
                pending++;
                low_len = 0;
            end
            if (!req_n) low_len++;
            if (!prev_req && req_n) begin
                if (lmin == 0 || low_len < lmin) lmin = low_len;
                if (low_len > lmax) lmax = low_len;
                last_rise = cyc;
            end
            if (prev_drv && !drv) tail_len = cyc - last_rise;
            if (done) done_cnt++;
        end
        if (!ack_n) ack_n = 1'b1;
        else if (pending > 0 && budget > 0) begin
            ack_n = 1'b0;
            pending--;
            budget--;
        end
        if (hs_pend) idx++;
        in_valid = (idx < feed_len);
        in_data  = pat(seed, idx);
        hs_pend  = in_valid && in_ready;
        prev_req = req_n;
        prev_drv = drv;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic arm(input int len, input int per, input int ofs, input int s, input int bud);
        step(1);
        seed = s; req_count = 0; pending = 0; budget = bud; idx = 0; feed_len = len;
        hs_pend = 0; done_cnt = 0; lmin = 0; lmax = 0; gmin = 0; gmax = 0; tail_len = -1;
        xfer_len = LEN_W'(len); cfg_period = PER_W'(per); cfg_offset = OFS_W'(ofs);
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && done_cnt == 0; i++) step(1);
        step(2);
    endtask

    task automatic t_reset;
        check(req_n == 1'b1, "R1", "req_n idle", int'(req_n), 1);
        check(data_n == 8'hFF && parity_n, "R1", "lines released", int'(data_n), 255);
        check(!busy && !done && !in_ready, "R1", "busy/done/ready idle",
              int'({busy, done, in_ready}), 0);
        check(acks_left == 0, "R1", "acks_left idle", int'(acks_left), 0);
    endtask

    task automatic t_bad_offset;
        arm(4, 5, 0, 1, 100);
        check(!busy, "R2", "zero offset refused", int'(busy), 0);
        check(cfg_err, "R2", "cfg_err raised", int'(cfg_err), 1);
        step(20);
        check(req_count == 0, "R2", "no REQ after refusal", req_count, 0);
    endtask

    task automatic t_basic;
        arm(6, 5, 4, 2, 1000);
        check(busy && !cfg_err, "R2", "legal start busy, err cleared",
              int'({busy, cfg_err}), 2);
        wait_done(400);
        check(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
        check(req_count == 6, "R3", "REQ count", req_count, 6);
        check(lmin == 1 && lmax == 1, "R4", "REQ low cycles period 5", lmax, 1);
        check(acks_left == 0 && !busy, "R8", "idle after done", int'(acks_left), 0);
    endtask

    task automatic t_rounding(input int per);
        int h;
        h = half_cyc(per);
        arm(3, per, 8, 3 + per, 1000);
        wait_done(600);
        check(lmin == h && lmax == h, "R4", "REQ low cycles", lmax, h);
        check(gmin == h && gmax == h, "R4", "REQ high gap cycles", gmax, h);
        check(tail_len == 2 * h, "R7", "data hold after last REQ", tail_len, 2 * h);
        check(done_cnt == 1 && req_count == 3, "R8", "rounded transfer done", done_cnt, 1);
    endtask

    task automatic t_throttle;
        arm(8, 5, 3, 4, 0);
        check(acks_left == 8, "R2", "acks_left loaded", int'(acks_left), 8);
        step(60);
        check(req_count == 3, "R5", "stall at offset", req_count, 3);
        check(busy && done_cnt == 0, "R5", "still busy while stalled", int'(busy), 1);
        budget = 1;
        step(20);
        check(req_count == 4, "R5", "one ACK frees one REQ", req_count, 4);
        check(acks_left == 7, "R6", "one ACK counted", int'(acks_left), 7);
        budget = 1000;
        wait_done(400);
        check(req_count == 8 && done_cnt == 1, "R5", "throttled transfer completes", req_count, 8);
    endtask

    task automatic t_hold_done;
        arm(3, 6, 8, 5, 0);
        step(60);
        check(req_count == 3, "R7", "all bytes sent", req_count, 3);
        check(req_n && data_n == 8'hFF && parity_n, "R7", "lines released", int'(data_n), 255);
        check(tail_len == 4, "R7", "tail hold cycles", tail_len, 4);
        check(busy && done_cnt == 0, "R8", "no done with ACKs owed", done_cnt, 0);
        check(acks_left == 3, "R6", "no ACK seen yet", int'(acks_left), 3);
        budget = 2;
        step(20);
        check(acks_left == 1, "R6", "two ACKs counted", int'(acks_left), 1);
        check(done_cnt == 0, "R8", "done waits for last ACK", done_cnt, 0);
        budget = 1000;
        wait_done(100);
        check(done_cnt == 1 && acks_left == 0, "R8", "done after last ACK", done_cnt, 1);
        pending = 2;
        step(20);
        check(acks_left == 0, "R6", "no underflow on extra ACKs", int'(acks_left), 0);
    endtask

    task automatic t_abort;
        arm(10, 5, 2, 6, 1);
        step(60);
        check(req_count == 3, "R5", "offset 2 with one ACK", req_count, 3);
        bus_rst = 1'b1;
        step(1);
        check(!busy, "R9", "abort to idle", int'(busy), 0);
        check(req_n && data_n == 8'hFF && parity_n, "R9", "lines released on abort",
              int'(data_n), 255);
        check(acks_left == 9, "R9", "remaining ACK count kept", int'(acks_left), 9);
        bus_rst = 1'b0;
        step(10);
        check(done_cnt == 0, "R9", "no done after abort", done_cnt, 0);
        pending = 0;
        budget = 0;
    endtask

    task automatic t_zero_len;
        arm(0, 5, 3, 7, 1000);
        wait_done(50);
        check(done_cnt == 1, "R10", "zero length done", done_cnt, 1);
        check(req_count == 0, "R10", "zero length no REQ", req_count, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_bad_offset();
        t_basic();
        t_rounding(6);
        t_rounding(25);
        t_throttle();
        t_hold_done();
        t_abort();
        t_zero_len();
        t_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule